// File: doc/BRIEF.md
# Command-Gated Serial Register Port

This block is the device-side serial port of a converter-style peripheral. A host reaches a small register file over four serial lines: an active-low select, a serial clock, a data input and a data output. An active-low ready line tells the host that a fresh conversion result is waiting. The serial lines are brought into the system clock domain and their edges are detected there. Every exchange starts with an 8-bit command byte. The command names the target register and says whether the next transfer reads from it or writes to it. Once that transfer is done, the port expects another command.

The conversion core sits outside this block. It hands each new result over a parallel load strobe. The ready line goes high for a cycle before the stored result changes, so a read can never overlap an update. The line falls together with the update and rises again when a full read of the result finishes. A host with no ready pin can read the command register and look at its top bit. A run of 32 or more ones on the data input realigns a host that has lost count of its bits. The realignment leaves every register as it was.

Top module: `sreg_slave`

## Requirements
- R1: After `rst_n` is released, `drdy_n` and `dout` are high, every configuration register reads zero, the stored result is zero and the port waits for a command.
- R2: A command byte is taken MSB first. Bits [6:4] give the address, bit 3 selects read (1) or write (0), and bit 7 must be 0. A byte with bit 7 set is dropped and the port keeps waiting for a command.
- R3: A write command to address 1, 2, 4, 5, 6 or 7 is followed by 8 data bits, MSB first, sampled on rising `sclk`. Those bits replace that register. Register k appears on `cfg_flat[8k+7:8k]`, and slots 0 and 3 read zero. Nothing else changes `cfg_flat`.
- R4: A read command is followed by the register contents on `dout`, MSB first, changed on falling `sclk`: 16 bits for address 3 and 8 bits for the other addresses. `dout` is high whenever no read is in progress.
- R5: When `res_load` is sampled, `drdy_n` is high on the next cycle. On the cycle after that, the stored result takes the loaded `res_data` and `drdy_n` goes low.
- R6: Completing all 16 bits of a result read raises `drdy_n`. The same value can be read again until the next load.
- R7: A read of address 0 returns `drdy_n` in bit 7 and bits [6:0] of that read command (0001000). This gives 8'h08 while a result is pending and 8'h88 otherwise.
- R8: Raising `cs_n` in the middle of a transfer abandons it without changing any register, and the port waits for a command.
- R9: 32 consecutive rising `sclk` edges with `din` at 1 return the port to waiting for a command, bit-aligned, with all registers unchanged.
- R10: A write to address 3 takes 16 data bits and discards them. A write command to address 0 has no data phase.
- R11: Asserting `rst_n` during a transfer returns the port to waiting for a command, with the registers back at their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Active-low select; high aborts any transfer |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial data from the host |
| dout | output | 1 | Serial data to the host, high when idle |
| drdy_n | output | 1 | Low while an unread result is pending |
| res_load | input | 1 | One-cycle strobe that loads a new result |
| res_data | input | 16 | Result word captured on `res_load` |
| cfg_flat | output | 64 | The eight 8-bit register slots, slot k at bits [8k+7:8k] |

## Verification
The bench targets framing errors. A port that decoded a command with bit 7 set would write a later command byte into a register as data. A port that did not realign on a run of ones would land three bits into a byte and decode garbage. A port that mis-sized a result write would take the following command byte as data. It also checks the ready handshake cycle by cycle. A port that updated the result before raising `drdy_n`, or that cleared `drdy_n` on reading some other register, would fail either the strobe timing checks or the repeat-read check. A `cs_n` abort and a reset in the middle of a transfer must both leave the data bits already shifted in with no effect.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  typedef enum logic [1:0] {
    PH_CMD = 2'd0,
    PH_WR  = 2'd1,
    PH_RD  = 2'd2
  } phase_e;
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
  parameter int N = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sreg_ready.sv
module sreg_ready #(
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             ld,
  input  logic [RES_W-1:0] ld_data,
  input  logic             rd_done,
  output logic             drdy_n,
  output logic [RES_W-1:0] res_q
);
  logic             rdy_q, rdy_d;
  logic             pend_q, pend_d;
  logic [RES_W-1:0] hold_q, hold_d;
  logic [RES_W-1:0] res_d;

  always_comb begin
    rdy_d  = rdy_q;
    pend_d = pend_q;
    hold_d = hold_q;
    res_d  = res_q;
    if (ld) begin
      rdy_d  = 1'b1;
      pend_d = 1'b1;
      hold_d = ld_data;
    end else if (pend_q) begin
      res_d  = hold_q;
      rdy_d  = 1'b0;
      pend_d = 1'b0;
    end else if (rd_done) begin
      rdy_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rdy_q  <= 1'b1;
      pend_q <= 1'b0;
      hold_q <= '0;
      res_q  <= '0;
    end else begin
      rdy_q  <= rdy_d;
      pend_q <= pend_d;
      if (ld) hold_q <= hold_d;
      if (pend_q && !ld) res_q <= res_d;
    end
  end

  assign drdy_n = rdy_q;
endmodule

// File: rtl/sreg_regfile.sv
module sreg_regfile #(
  parameter int REG_W = 8,
  parameter int ADDR_W = 3,
  parameter int RES_ADDR = 3
) (
  input  logic                         clk,
  input  logic                         arst_n,
  input  logic                         we,
  input  logic [ADDR_W-1:0]            waddr,
  input  logic [REG_W-1:0]             wdata,
  input  logic [ADDR_W-1:0]            raddr,
  output logic [REG_W-1:0]             rdata,
  output logic [(1<<ADDR_W)*REG_W-1:0] flat
);
  localparam int NREG = 1 << ADDR_W;

  for (genvar k = 0; k < NREG; k++) begin : g_slot
    if (k == 0 || k == RES_ADDR) begin : g_none
      assign flat[k*REG_W +: REG_W] = '0;
    end else begin : g_reg
      logic [REG_W-1:0] q;
      logic             hit;
      assign hit = we && (waddr == ADDR_W'(k));
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)  q <= '0;
        else if (hit) q <= wdata;
      end
      assign flat[k*REG_W +: REG_W] = q;
    end
  end

  assign rdata = flat[raddr*REG_W +: REG_W];
endmodule

// File: rtl/sreg_engine.sv
module sreg_engine
  import sreg_pkg::*;
#(
  parameter int REG_W = 8,
  parameter int RES_W = 16,
  parameter int ADDR_W = 3,
  parameter int RES_ADDR = 3,
  parameter int RESYNC_ONES = 32
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              cs_n_s,
  input  logic              sclk_s,
  input  logic              din_s,
  input  logic              drdy_n,
  input  logic [RES_W-1:0]  res_q,
  input  logic [REG_W-1:0]  cfg_rdata,
  output logic [ADDR_W-1:0] cfg_raddr,
  output logic              cfg_we,
  output logic [ADDR_W-1:0] cfg_waddr,
  output logic [REG_W-1:0]  cfg_wdata,
  output logic              rd_done,
  output logic              dout
);
  localparam int CNT_W    = $clog2(RES_W + 1);
  localparam int ONES_W   = $clog2(RESYNC_ONES + 1);
  localparam int PAD      = RES_W - REG_W;
  localparam int FLAG_BIT = REG_W - 1;
  localparam int ADDR_LSB = REG_W - 1 - ADDR_W;
  localparam int RW_BIT   = ADDR_LSB - 1;
  localparam logic [ADDR_W-1:0] RES_A    = ADDR_W'(RES_ADDR);
  localparam logic [CNT_W-1:0]  LAST_REG = CNT_W'(REG_W - 1);
  localparam logic [CNT_W-1:0]  LAST_RES = CNT_W'(RES_W - 1);
  localparam logic [ONES_W-1:0] ONES_TRIP = ONES_W'(RESYNC_ONES - 1);
  localparam logic [ONES_W-1:0] ONES_SAT  = ONES_W'(RESYNC_ONES);

  phase_e            phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [REG_W-1:0]  rx_q, rx_d, rx_next;
  logic [RES_W-1:0]  tx_q, tx_d, rd_word;
  logic [ONES_W-1:0] ones_q, ones_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              dout_q, dout_d;
  logic              sclk_q;
  logic              we_q, we_d;
  logic [REG_W-1:0]  wdata_q, wdata_d;
  logic              done_q, done_d;
  logic              rise, fall, trip;
  logic [CNT_W-1:0]  cur_last;

  assign rise      = sclk_s & ~sclk_q;
  assign fall      = ~sclk_s & sclk_q;
  assign rx_next   = {rx_q[REG_W-2:0], din_s};
  assign cfg_raddr = rx_next[ADDR_LSB +: ADDR_W];
  assign trip      = din_s && (ones_q >= ONES_TRIP);
  assign cur_last  = (addr_q == RES_A) ? LAST_RES : LAST_REG;

  always_comb begin
    if (cfg_raddr == '0)
      rd_word = {drdy_n, rx_next[REG_W-2:0], {PAD{1'b0}}};
    else if (cfg_raddr == RES_A)
      rd_word = res_q;
    else
      rd_word = {cfg_rdata, {PAD{1'b0}}};
  end

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    rx_d    = rx_q;
    tx_d    = tx_q;
    ones_d  = ones_q;
    addr_d  = addr_q;
    dout_d  = dout_q;
    we_d    = 1'b0;
    wdata_d = wdata_q;
    done_d  = 1'b0;
    if (cs_n_s) begin
      phase_d = PH_CMD;
      cnt_d   = '0;
      ones_d  = '0;
      dout_d  = 1'b1;
    end else if (rise) begin
      ones_d = din_s ? ((ones_q == ONES_SAT) ? ones_q : ones_q + 1'b1) : '0;
      rx_d   = rx_next;
      if (trip) begin
        phase_d = PH_CMD;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
        unique case (phase_q)
          PH_CMD: begin
            if (cnt_q == LAST_REG) begin
              cnt_d = '0;
              if (!rx_next[FLAG_BIT]) begin
                addr_d = cfg_raddr;
                if (rx_next[RW_BIT]) begin
                  phase_d = PH_RD;
                  tx_d    = rd_word;
                end else if (cfg_raddr != '0) begin
                  phase_d = PH_WR;
                end
              end
            end
          end
          PH_WR: begin
            if (cnt_q == cur_last) begin
              cnt_d   = '0;
              phase_d = PH_CMD;
              if (addr_q != RES_A) begin
                we_d    = 1'b1;
                wdata_d = rx_next;
              end
            end
          end
          PH_RD: begin
            if (cnt_q == cur_last) begin
              cnt_d   = '0;
              phase_d = PH_CMD;
              done_d  = (addr_q == RES_A);
            end
          end
          default: begin
            phase_d = PH_CMD;
            cnt_d   = '0;
          end
        endcase
      end
    end else if (fall) begin
      if (phase_q == PH_RD) begin
        dout_d = tx_q[RES_W-1];
        tx_d   = {tx_q[RES_W-2:0], 1'b0};
      end else begin
        dout_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      phase_q <= PH_CMD;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      ones_q  <= '0;
      addr_q  <= '0;
      dout_q  <= 1'b1;
      sclk_q  <= 1'b0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      rx_q    <= rx_d;
      tx_q    <= tx_d;
      ones_q  <= ones_d;
      addr_q  <= addr_d;
      dout_q  <= dout_d;
      sclk_q  <= sclk_s;
      we_q    <= we_d;
      wdata_q <= wdata_d;
      done_q  <= done_d;
    end
  end

  assign cfg_we    = we_q;
  assign cfg_waddr = addr_q;
  assign cfg_wdata = wdata_q;
  assign rd_done   = done_q;
  assign dout      = dout_q;
endmodule

// File: rtl/sreg_slave.sv
module sreg_slave #(
  parameter int REG_W = 8,
  parameter int RES_W = 16,
  parameter int ADDR_W = 3,
  parameter int RES_ADDR = 3,
  parameter int RESYNC_ONES = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cs_n,
  input  logic                             sclk,
  input  logic                             din,
  output logic                             dout,
  output logic                             drdy_n,
  input  logic                             res_load,
  input  logic [RES_W-1:0]                 res_data,
  output logic [(1<<ADDR_W)*REG_W-1:0]     cfg_flat
);
  logic             rst_m, arst_n;
  logic [2:0]       pins_s;
  logic             cs_n_s, sclk_s, din_s;
  logic [RES_W-1:0] res_q;
  logic             rd_done;
  logic             cfg_we;
  logic [ADDR_W-1:0] cfg_waddr, cfg_raddr;
  logic [REG_W-1:0] cfg_wdata, cfg_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m  <= 1'b0;
      arst_n <= 1'b0;
    end else begin
      rst_m  <= 1'b1;
      arst_n <= rst_m;
    end
  end

  sreg_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk(clk), .arst_n(arst_n), .d({sclk, din, cs_n}), .q(pins_s)
  );
  assign sclk_s = pins_s[2];
  assign din_s  = pins_s[1];
  assign cs_n_s = pins_s[0];

  sreg_engine #(
    .REG_W(REG_W), .RES_W(RES_W), .ADDR_W(ADDR_W),
    .RES_ADDR(RES_ADDR), .RESYNC_ONES(RESYNC_ONES)
  ) u_eng (
    .clk(clk), .arst_n(arst_n), .cs_n_s(cs_n_s), .sclk_s(sclk_s), .din_s(din_s),
    .drdy_n(drdy_n), .res_q(res_q), .cfg_rdata(cfg_rdata), .cfg_raddr(cfg_raddr),
    .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
    .rd_done(rd_done), .dout(dout)
  );

  sreg_regfile #(.REG_W(REG_W), .ADDR_W(ADDR_W), .RES_ADDR(RES_ADDR)) u_rf (
    .clk(clk), .arst_n(arst_n), .we(cfg_we), .waddr(cfg_waddr), .wdata(cfg_wdata),
    .raddr(cfg_raddr), .rdata(cfg_rdata), .flat(cfg_flat)
  );

  sreg_ready #(.RES_W(RES_W)) u_rdy (
    .clk(clk), .arst_n(arst_n), .ld(res_load), .ld_data(res_data),
    .rd_done(rd_done), .drdy_n(drdy_n), .res_q(res_q)
  );
endmodule

// File: rtl/sreg_slave_chk.sv
module sreg_slave_chk #(
  parameter int REG_W = 8,
  parameter int RES_W = 16,
  parameter int ADDR_W = 3,
  parameter int RES_ADDR = 3
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         cs_n,
  input logic                         dout,
  input logic                         drdy_n,
  input logic                         res_load,
  input logic [RES_W-1:0]             res_q,
  input logic                         rd_done,
  input logic                         cfg_we,
  input logic [ADDR_W-1:0]            cfg_waddr,
  input logic [(1<<ADDR_W)*REG_W-1:0] cfg_flat
);
  a_r3_cfg_only_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_flat));

  a_r10_no_write_to_fixed_slots: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> (cfg_waddr != '0) && (cfg_waddr != ADDR_W'(RES_ADDR)));

  a_r4_dout_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) && $past(cs_n, 4)) |-> dout);

  a_r5_load_raises_ready: assert property (@(posedge clk) disable iff (!rst_n)
    res_load |=> drdy_n);

  a_r5_update_after_high: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res_q) |-> ($past(drdy_n) && !drdy_n));

  a_r6_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drdy_n) |-> ($past(res_load) || $past(rd_done)));
endmodule

bind sreg_slave sreg_slave_chk #(
  .REG_W(REG_W), .RES_W(RES_W), .ADDR_W(ADDR_W), .RES_ADDR(RES_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dout(dout), .drdy_n(drdy_n),
  .res_load(res_load), .res_q(res_q), .rd_done(rd_done), .cfg_we(cfg_we),
  .cfg_waddr(cfg_waddr), .cfg_flat(cfg_flat)
);

// File: tb/sreg_slave_test.sv
module sreg_slave_test;
  localparam int HP = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic        din = 1'b0;
  logic        dout, drdy_n;
  logic        res_load = 1'b0;
  logic [15:0] res_data = '0;
  logic [63:0] cfg_flat;

  int checks = 0;
  int failures = 0;
  logic [7:0] model [8];

  sreg_slave uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din), .dout(dout),
    .drdy_n(drdy_n), .res_load(res_load), .res_data(res_data), .cfg_flat(cfg_flat)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] cmd(input logic [2:0] a, input logic rd);
    return {1'b0, a, rd, 3'b000};
  endfunction

  function automatic logic [63:0] model_flat();
    logic [63:0] f;
    for (int k = 0; k < 8; k++) f[k*8 +: 8] = (k == 0 || k == 3) ? 8'h00 : model[k];
    return f;
  endfunction

  task automatic sbit(input logic b, output logic r);
    din = b;
    repeat (HP) @(negedge clk);
    r = dout;
    sclk = 1'b1;
    repeat (HP) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic shift(input int n, input logic [15:0] wv, output logic [15:0] rv);
    logic r;
    rv = '0;
    for (int i = n - 1; i >= 0; i--) begin
      sbit(wv[i], r);
      rv[i] = r;
    end
  endtask

  task automatic cs_lo();
    cs_n = 1'b0;
    repeat (HP) @(negedge clk);
  endtask

  task automatic cs_hi();
    repeat (HP) @(negedge clk);
    cs_n = 1'b1;
    repeat (2 * HP) @(negedge clk);
  endtask

  task automatic wr8(input logic [2:0] a, input logic [7:0] v);
    logic [15:0] rv;
    cs_lo();
    shift(8, {8'h00, cmd(a, 1'b0)}, rv);
    shift(8, {8'h00, v}, rv);
    cs_hi();
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    logic [15:0] rv;
    cs_lo();
    shift(8, {8'h00, cmd(a, 1'b1)}, rv);
    shift((a == 3'd3) ? 16 : 8, 16'h0000, v);
    cs_hi();
  endtask

  task automatic load(input logic [15:0] v);
    @(negedge clk);
    res_load = 1'b1;
    res_data = v;
    @(negedge clk);
    res_load = 1'b0;
    res_data = 16'hDEAD;
    chk("R5 drdy_n high cycle after load", {63'h0, drdy_n}, 64'h1);
    @(negedge clk);
    chk("R5 drdy_n low with update", {63'h0, drdy_n}, 64'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [15:0] rv;
    for (int k = 0; k < 8; k++) model[k] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk("R1 drdy_n after reset", {63'h0, drdy_n}, 64'h1);
    chk("R1 dout after reset", {63'h0, dout}, 64'h1);
    chk("R1 cfg_flat after reset", cfg_flat, 64'h0);
    rd(3'd3, v);
    chk("R1 result after reset", {48'h0, v}, 64'h0);
    rd(3'd0, v);
    chk("R7 command read with no result", {48'h0, v}, 64'h88);

    // R3 / R4 sweep over every writable slot
    for (int a = 1; a < 8; a++) begin
      if (a != 3) begin
        model[a] = 8'(a * 8'h1D + 8'h35);
        wr8(3'(a), model[a]);
        chk("R3 cfg_flat after write", cfg_flat, model_flat());
      end
    end
    for (int a = 1; a < 8; a++) begin
      if (a != 3) begin
        rd(3'(a), v);
        chk("R4 readback of slot", {48'h0, v}, {56'h0, model[a]});
      end
    end
    chk("R4 dout idle between transfers", {63'h0, dout}, 64'h1);
    for (int i = 0; i < 16; i++) begin
      model[7] = 8'(i * 17) ^ 8'h0F;
      wr8(3'd7, model[7]);
      rd(3'd7, v);
      chk("R4 slot 7 value sweep", {48'h0, v}, {56'h0, model[7]});
    end
    chk("R3 cfg_flat after sweep", cfg_flat, model_flat());

    // R2 byte with bit 7 set is dropped; following byte is a command
    cs_lo();
    shift(8, 16'h0090, rv);
    shift(8, {8'h00, cmd(3'd1, 1'b0)}, rv);
    shift(8, 16'h0033, rv);
    cs_hi();
    model[1] = 8'h33;
    chk("R2 flagged command discarded", cfg_flat, model_flat());

    // R10 result write discarded, write to address 0 has no data phase
    cs_lo();
    shift(8, {8'h00, cmd(3'd3, 1'b0)}, rv);
    shift(16, 16'h1234, rv);
    shift(8, {8'h00, cmd(3'd0, 1'b0)}, rv);
    shift(8, {8'h00, cmd(3'd6, 1'b0)}, rv);
    shift(8, 16'h0066, rv);
    cs_hi();
    model[6] = 8'h66;
    chk("R10 framing after fixed-slot writes", cfg_flat, model_flat());
    rd(3'd3, v);
    chk("R10 result untouched by write", {48'h0, v}, 64'h0);

    // R8 abort part way through a data byte
    cs_lo();
    shift(8, {8'h00, cmd(3'd2, 1'b0)}, rv);
    shift(4, 16'h000F, rv);
    cs_hi();
    chk("R8 abort leaves slot 2", cfg_flat, model_flat());
    wr8(3'd4, 8'h77);
    model[4] = 8'h77;
    chk("R8 command accepted after abort", cfg_flat, model_flat());

    // R5 R6 R7 ready handshake
    load(16'hA55A);
    rd(3'd0, v);
    chk("R7 command read with result pending", {48'h0, v}, 64'h08);
    chk("R6 ready still low after other read", {63'h0, drdy_n}, 64'h0);
    rd(3'd3, v);
    chk("R6 result value", {48'h0, v}, 64'hA55A);
    chk("R6 ready high after result read", {63'h0, drdy_n}, 64'h1);
    rd(3'd3, v);
    chk("R6 repeat read same value", {48'h0, v}, 64'hA55A);
    load(16'h0F81);
    rd(3'd3, v);
    chk("R5 second load value", {48'h0, v}, 64'h0F81);

    // R9 resync from a misaligned point, all in one select window
    cs_lo();
    shift(3, 16'h0002, rv);
    for (int i = 0; i < 40; i++) sbit(1'b1, rv[0]);
    chk("R9 registers kept by ones run", cfg_flat, model_flat());
    shift(8, {8'h00, cmd(3'd5, 1'b0)}, rv);
    shift(8, 16'h00C3, rv);
    cs_hi();
    model[5] = 8'hC3;
    chk("R9 aligned after ones run", cfg_flat, model_flat());

    // R11 reset during a transfer
    cs_lo();
    shift(8, {8'h00, cmd(3'd2, 1'b0)}, rv);
    shift(4, 16'h0005, rv);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    for (int k = 0; k < 8; k++) model[k] = 8'h00;
    chk("R11 registers cleared", cfg_flat, 64'h0);
    chk("R11 ready high", {63'h0, drdy_n}, 64'h1);
    shift(8, {8'h00, cmd(3'd2, 1'b0)}, rv);
    shift(8, 16'h009C, rv);
    cs_hi();
    model[2] = 8'h9C;
    chk("R11 command accepted after reset", cfg_flat, model_flat());

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule